// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Sign-Aware Digit Display

This block takes two 3-bit two's complement operands and a mode bit, all held as static levels (for example from switches). It forms their signed sum or difference as a 4-bit two's complement result, so the result never wraps. The result is then shown on a multiplexed, common-anode seven-segment display.

A result of zero or more lights a single display position with its decimal digit. A negative result uses two positions. One position shows the magnitude digit and the next shows a minus sign. A refresh counter switches between the two quickly enough that both appear steady.

The operands and the mode bit are plain levels, sampled on every clock. There is no valid/ready handshake because nothing is queued or consumed, so there is never any back-pressure. The display outputs always reflect the operands as they were one clock earlier.

Top module: `signed_addsub_display`

## Requirements
- R1: With `sub_mode` = 0, the value shown equals the signed sum of `op_a` and `op_b`, each read as 3-bit two's complement.
- R2: With `sub_mode` = 1, the value shown equals `op_a` minus `op_b`. Internally, `op_b` is XORed with the mode bit and the mode bit is also the carry-in.
- R3: The 4-bit result's MSB is the carry out of bit 2 when that carry differs from the carry into bit 2, and sum bit 2 otherwise. Results of 7 (3 - (-4)) and -8 (-4 + -4) are therefore shown exactly.
- R4: For a result of 0 or more, only position 0 is enabled (`an_n` = 4'b1110) and it shows the result's decimal digit. This holds on every cycle.
- R5: For a negative result, position 0 (`an_n` = 4'b1110) showing the magnitude alternates with position 1 (`an_n` = 4'b1101) showing a minus sign (`seg_n` = 7'b0111111, only g lit). Each is held for `REFRESH_CYCLES` clocks.
- R6: Segments are active low, with `seg_n[0]` = a up to `seg_n[6]` = g. The digits 0 to 8 use the usual patterns, for example 0 = 7'b1000000, 1 = 7'b1111001 and 8 = 7'b0000000.
- R7: Positions 2 and 3 are dark at all times. While `rst_n` is low, all positions are dark and all segments are off.
- R8: `seg_n` and `an_n` come from one register stage and change on the same edge. A new operand value appears on the clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock driving the display refresh |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 3 | First operand, two's complement |
| op_b | input | 3 | Second operand, two's complement |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| seg_n | output | 7 | Active-low segments, bit 0 = a through bit 6 = g |
| an_n | output | 4 | Active-low position enables (NUM_POS wide) |

## Verification
The arithmetic result is due one clock after the operands change, since a single register stage feeds both `seg_n` and `an_n`. For a nonnegative result, the bench therefore checks the first falling edge after the next rising edge. A minus sign is due within one refresh period of the value becoming negative. For that reason the bench observes a window of 2·`REFRESH_CYCLES`+2 cycles for every operand set, and it samples only on falling edges. The checks in that window cover:
- whether both positions appeared;
- that each showed the correct pattern;
- that positions 2 and 3 never lit.

// File: rtl/sdisp_pkg.sv
package sdisp_pkg;
  // Operand width: a single decimal digit can hold the full result range only at 3 bits.
  localparam int DATA_W = 3;
  localparam int RES_W  = DATA_W + 1;

  localparam logic [6:0] SEG_BLANK_N = 7'b1111111;
  localparam logic [6:0] SEG_MINUS_N = 7'b0111111;

  // Active-low pattern, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] digit_to_seg_n(input logic [RES_W-1:0] d);
    logic [6:0] on;
    case (d)
      4'd0: on = 7'b0111111;
      4'd1: on = 7'b0000110;
      4'd2: on = 7'b1011011;
      4'd3: on = 7'b1001111;
      4'd4: on = 7'b1100110;
      4'd5: on = 7'b1101101;
      4'd6: on = 7'b1111101;
      4'd7: on = 7'b0000111;
      4'd8: on = 7'b1111111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/sd_addsub.sv
module sd_addsub #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W:0]   res
);
  logic [W:0]   carry;
  logic [W-1:0] b_x;
  logic [W-1:0] s;

  assign carry[0] = sub;
  assign b_x      = b ^ {W{sub}};

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign s[i]       = a[i] ^ b_x[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b_x[i]) | (carry[i] & (a[i] ^ b_x[i]));
    end
  endgenerate

  // Overflow picks the extension bit: carry-out when the top carries disagree.
  assign res = {(carry[W] ^ carry[W-1]) ? carry[W] : s[W-1], s};
endmodule

// File: rtl/sd_magnitude.sv
module sd_magnitude #(
  parameter int RW = 4
) (
  input  logic [RW-1:0] res,
  output logic          neg,
  output logic [RW-1:0] mag
);
  assign neg = res[RW-1];
  assign mag = neg ? (~res + RW'(1)) : res;
endmodule

// File: rtl/sd_scan.sv
module sd_scan
  import sdisp_pkg::*;
#(
  parameter int REFRESH_CYCLES = 100000,
  parameter int NUM_POS        = 4,
  parameter int DIGIT_POS      = 0,
  parameter int SIGN_POS       = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               neg,
  input  logic [RES_W-1:0]   mag,
  output logic [6:0]         seg_n,
  output logic [NUM_POS-1:0] an_n
);
  localparam int CNT_W = (REFRESH_CYCLES > 1) ? $clog2(REFRESH_CYCLES) : 1;
  localparam logic [CNT_W-1:0]   CNT_LAST = CNT_W'(REFRESH_CYCLES - 1);
  localparam logic [NUM_POS-1:0] DIGIT_ON_N = ~(NUM_POS'(1) << DIGIT_POS);
  localparam logic [NUM_POS-1:0] SIGN_ON_N  = ~(NUM_POS'(1) << SIGN_POS);
  localparam logic [NUM_POS-1:0] USED_MASK  = ~(DIGIT_ON_N & SIGN_ON_N);

  logic [CNT_W-1:0]   cnt;
  logic               phase;
  logic [NUM_POS-1:0] an_next;
  logic [6:0]         seg_next;

  always_comb begin
    if (neg && phase) begin
      an_next  = SIGN_ON_N;
      seg_next = SEG_MINUS_N;
    end else begin
      an_next  = DIGIT_ON_N;
      seg_next = digit_to_seg_n(mag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
      an_n  <= '1;
      seg_n <= SEG_BLANK_N;
    end else begin
      if (cnt == CNT_LAST) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      an_n  <= an_next;
      seg_n <= seg_next;
    end
  end

  // R7: at most one position lit, unused positions never lit
  a_r7_unused_dark: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~an_n) <= 1) && (&(an_n | USED_MASK)));

  // R4: a nonnegative value keeps the digit position alone
  a_r4_single_position: assert property (@(posedge clk) disable iff (!rst_n)
    !neg |=> (an_n == DIGIT_ON_N));

  // R5: the sign position only ever carries the minus pattern
  a_r5_minus_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (an_n == SIGN_ON_N) |-> (seg_n == SEG_MINUS_N));

  // R8: lit digit position shows the magnitude registered one edge before
  a_r8_digit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (an_next == DIGIT_ON_N) |=> (seg_n == digit_to_seg_n($past(mag))));
endmodule

// File: rtl/signed_addsub_display.sv
module signed_addsub_display
  import sdisp_pkg::*;
#(
  parameter int REFRESH_CYCLES = 100000,
  parameter int NUM_POS        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  op_a,
  input  logic [DATA_W-1:0]  op_b,
  input  logic               sub_mode,
  output logic [6:0]         seg_n,
  output logic [NUM_POS-1:0] an_n
);
  logic [RES_W-1:0] result;
  logic             neg;
  logic [RES_W-1:0] mag;

  sd_addsub #(.W(DATA_W)) u_addsub (
    .a   (op_a),
    .b   (op_b),
    .sub (sub_mode),
    .res (result)
  );

  sd_magnitude #(.RW(RES_W)) u_mag (
    .res (result),
    .neg (neg),
    .mag (mag)
  );

  sd_scan #(
    .REFRESH_CYCLES (REFRESH_CYCLES),
    .NUM_POS        (NUM_POS),
    .DIGIT_POS      (0),
    .SIGN_POS       (1)
  ) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .neg   (neg),
    .mag   (mag),
    .seg_n (seg_n),
    .an_n  (an_n)
  );

  // R1, R2, R3: result equals the exact signed arithmetic, never wrapped
  logic signed [RES_W:0] exact;
  always_comb begin
    if (sub_mode)
      exact = $signed({{2{op_a[DATA_W-1]}}, op_a}) - $signed({{2{op_b[DATA_W-1]}}, op_b});
    else
      exact = $signed({{2{op_a[DATA_W-1]}}, op_a}) + $signed({{2{op_b[DATA_W-1]}}, op_b});
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (result == exact[RES_W-1:0]) && (exact[RES_W] == exact[RES_W-1]));
endmodule

// File: tb/signed_addsub_display_tb.sv
`timescale 1ns/1ps
module signed_addsub_display_tb;
  localparam int REFRESH = 8;
  localparam int WINDOW  = 2 * REFRESH + 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_a = '0;
  logic [2:0] op_b = '0;
  logic       sub_mode = 1'b0;
  logic [6:0] seg_n;
  logic [3:0] an_n;

  always #2.5 clk = ~clk;

  signed_addsub_display #(.REFRESH_CYCLES(REFRESH), .NUM_POS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .sub_mode(sub_mode), .seg_n(seg_n), .an_n(an_n)
  );

  typedef struct {
    bit         neg;
    logic [6:0] seg_exp;
    int         value;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int done_cnt = 0;
  bit finished = 0;

  function automatic logic [6:0] seg_for(int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      default: return 7'bxxxxxxx;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver: applies operands, pushes the expected display into the queue
  initial begin
    repeat (5) @(negedge clk);
    check(an_n == 4'b1111 && seg_n == 7'b1111111, "R7", "reset dark",
          {an_n, seg_n}, {4'b1111, 7'b1111111});
    rst_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          int av, bv, r;
          exp_t it;
          @(negedge clk);
          op_a = 3'(a); op_b = 3'(b); sub_mode = s[0];
          av = (a > 3) ? a - 8 : a;
          bv = (b > 3) ? b - 8 : b;
          r  = s ? av - bv : av + bv;
          it.neg     = (r < 0);
          it.seg_exp = seg_for(r < 0 ? -r : r);
          it.value   = r;
          it.tag     = s ? "R2" : "R1";
          if (r == 7 || r == -8) it.tag = {it.tag, "/R3"};
          q.push_back(it);
          pushed++;
          wait (done_cnt == pushed);
        end
      end
    end
    finished = 1;
    summary();
    $finish;
  end

  // Monitor: pops expectations and compares against the display
  initial begin
    forever begin
      exp_t it;
      bit saw_digit, saw_minus, bad_digit, bad_minus, lit_unused, stray;
      wait (q.size() > 0);
      it = q.pop_front();
      @(posedge clk);
      @(negedge clk);
      if (!it.neg)
        check(an_n == 4'b1110 && seg_n == it.seg_exp, "R8", "one-edge update",
              {an_n, seg_n}, {4'b1110, it.seg_exp});
      saw_digit = 0; saw_minus = 0; bad_digit = 0; bad_minus = 0;
      lit_unused = 0; stray = 0;
      for (int k = 0; k < WINDOW; k++) begin
        if (k > 0) @(negedge clk);
        if (an_n[3:2] != 2'b11) lit_unused = 1;
        if (an_n == 4'b1110) begin
          saw_digit = 1;
          if (seg_n != it.seg_exp) bad_digit = 1;
        end else if (an_n == 4'b1101) begin
          saw_minus = 1;
          if (seg_n != 7'b0111111) bad_minus = 1;
        end else if (an_n[1:0] != 2'b11) begin
          stray = 1;
        end
      end
      // R6 digit pattern for the signed value
      check(saw_digit && !bad_digit && !stray, {it.tag, "/R6"}, "digit shown",
            it.value, it.seg_exp);
      check(!lit_unused, "R7", "unused positions dark", lit_unused, 0);
      if (it.neg)
        check(saw_minus && !bad_minus, "R5", "minus alternates",
              {saw_minus, bad_minus}, 2'b10);
      else
        check(!saw_minus, "R4", "single position only", saw_minus, 0);
      done_cnt++;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule